// File: doc/BRIEF.md
# Ownership-Prefetching Write Buffer

This block sits between a processor and its private cache in a system that keeps sequential consistency with an invalidation-based coherence protocol. Stores enter a queue in program order. Only the oldest store may write into the cache. While younger stores wait for their turn, the block sends exclusive-ownership requests for their lines. A line that comes back is held as if no other cache had a copy. The later commit then overlaps the work ahead of it instead of starting its ownership miss only when it reaches the head.

The processor stalls a store while the queue is full. It stalls a read miss until every buffered store has committed. Ownership requests go out oldest line first, and only one request is made per line while that line has entries in the queue. If an invalidation takes away a granted line before its store commits, the block forgets the grant and asks for the line again.

Handshakes: `wr_*`, `pf_*` and `cm_*` are valid/ready channels. A transfer happens on a cycle where both valid and ready are high.
- A store held on `wr_valid` must stay until it is accepted.
- `wr_ready` depends only on the current fill level. A full buffer refuses a store even in a cycle where the head commits.
- `pf_valid` and `pf_addr` hold until they are accepted, except in a cycle with `inv_valid`.
- `cm_valid`, `cm_addr` and `cm_data` hold while `cm_ready` is low, except in a cycle with `inv_valid`. An invalidation of the head line withdraws the commit.
- Grants and invalidations are single-cycle pulses and have no back-pressure.

Top module: `own_prefetch_wbuf`

## Requirements
- R1: A store is taken on a cycle with `wr_valid` and `wr_ready` both high. `wr_ready` is low exactly when DEPTH stores are held, including cycles in which the head commits.
- R2: `rd_ready` is high only when no store is buffered. `rd_issue` is high exactly when `rd_valid` and `rd_ready` are both high.
- R3: Commits leave in the order the stores were accepted. `cm_addr` and `cm_data` always show the oldest held store, with the address and data it was written with.
- R4: `cm_valid` is high only when the oldest store's line ownership has been granted. With `cm_ready` high, such a store retires in that cycle.
- R5: `pf_valid` is high while any held store's line has no outstanding or granted request. `pf_addr` is the line of the oldest such store. A transfer on the `pf` channel marks that line requested.
- R6: Each line has at most one ownership request at a time. A store to a line that already has a request (pending or granted) inherits that state and raises no new request.
- R7: A `gnt_valid` pulse marks every held store on line `gnt_addr` as owned if that line was requested. A grant to a line with no request has no effect.
- R8: An `inv_valid` pulse on a line that is granted but not yet committed clears the grant and the request, so the line is offered again on `pf`.
- R8 (continued): An invalidation of an ungranted line has no effect. When a grant and an invalidation hit the same line in the same cycle, the invalidation wins.
- R9: During and right after reset the buffer is empty: `wr_ready`=1, `rd_ready`=1, `pf_valid`=0 and `cm_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Processor store request |
| wr_ready | output | 1 | Buffer can take a store |
| wr_addr | input | AW | Line address of the store |
| wr_data | input | DW | Store data |
| rd_valid | input | 1 | Processor read-miss request |
| rd_ready | output | 1 | Read miss may proceed (no buffered stores) |
| rd_issue | output | 1 | Read miss forwarded this cycle |
| pf_valid | output | 1 | Ownership request pending issue |
| pf_ready | input | 1 | Coherence side takes the ownership request |
| pf_addr | output | AW | Line to own exclusively |
| gnt_valid | input | 1 | Exclusive ownership granted |
| gnt_addr | input | AW | Line that was granted |
| inv_valid | input | 1 | Invalidation received |
| inv_addr | input | AW | Line invalidated |
| cm_valid | output | 1 | Oldest store ready to write into the cache |
| cm_ready | input | 1 | Cache accepts the commit |
| cm_addr | output | AW | Commit line address |
| cm_data | output | DW | Commit data |

## Verification
The assertions check properties that must hold on every cycle:
- the fill count moves by exactly one accept minus one commit;
- the count never passes DEPTH;
- the commit and ownership-request channels hold their payload while stalled;
- a read miss is never forwarded while any store or request is still pending;
- a line that was just requested is not offered again on the next cycle.

Only the bench's scenarios can show the properties that depend on history:
- commits keep program order with the correct data;
- a second store to a requested line inherits its state;
- stray grants are ignored;
- a revoked grant brings a fresh request;
- an invalidation beats a grant in the same cycle.

// File: rtl/opw_pkg.sv
package opw_pkg;
  // Per-entry ownership state: request issued, exclusive ownership held.
  typedef struct packed {
    logic req;
    logic own;
  } own_flags_t;
endpackage

// File: rtl/opw_line_match.sv
module opw_line_match #(
  parameter int N  = 8,
  parameter int AW = 16
) (
  input  logic [N-1:0][AW-1:0] ents,
  input  logic [N-1:0]         live,
  input  logic [AW-1:0]        key,
  output logic [N-1:0]         hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = live[g] && (ents[g] == key);
  end
endmodule

// File: rtl/opw_oldest.sv
module opw_oldest #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/own_prefetch_wbuf.sv
module own_prefetch_wbuf
  import opw_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  output logic          rd_issue,
  output logic          pf_valid,
  input  logic          pf_ready,
  output logic [AW-1:0] pf_addr,
  input  logic          gnt_valid,
  input  logic [AW-1:0] gnt_addr,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_addr,
  output logic          cm_valid,
  input  logic          cm_ready,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][AW-1:0] addr_q, addr_n;
  logic [DEPTH-1:0][DW-1:0] data_q, data_n;
  own_flags_t [DEPTH-1:0]   flg_q, flg_n, upd;
  logic [CW-1:0]            cnt_q, cnt_n;

  logic [DEPTH-1:0] live, unreq, gnt_hit, inv_hit, pf_hit, wr_hit;
  logic             pf_found;
  logic [IW-1:0]    pf_idx;
  logic             wr_fire, pf_fire, cm_fire;
  own_flags_t       inherit;
  logic [CW-1:0]    slot;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      live[i]  = (i < int'(cnt_q));
      unreq[i] = live[i] && !flg_q[i].req;
    end
  end

  opw_oldest #(.N(DEPTH)) u_pick (.vec(unreq), .found(pf_found), .idx(pf_idx));

  opw_line_match #(.N(DEPTH), .AW(AW)) u_m_gnt (.ents(addr_q), .live(live), .key(gnt_addr), .hit(gnt_hit));
  opw_line_match #(.N(DEPTH), .AW(AW)) u_m_inv (.ents(addr_q), .live(live), .key(inv_addr), .hit(inv_hit));
  opw_line_match #(.N(DEPTH), .AW(AW)) u_m_pf  (.ents(addr_q), .live(live), .key(pf_addr),  .hit(pf_hit));
  opw_line_match #(.N(DEPTH), .AW(AW)) u_m_wr  (.ents(addr_q), .live(live), .key(wr_addr),  .hit(wr_hit));

  assign wr_ready = (cnt_q < CW'(DEPTH));
  assign rd_ready = (cnt_q == '0);
  assign rd_issue = rd_valid && rd_ready;
  assign pf_valid = pf_found;
  assign pf_addr  = addr_q[pf_idx];
  assign cm_valid = live[0] && flg_q[0].own;
  assign cm_addr  = addr_q[0];
  assign cm_data  = data_q[0];

  assign wr_fire = wr_valid && wr_ready;
  assign pf_fire = pf_valid && pf_ready;
  assign cm_fire = cm_valid && cm_ready;

  // Flag update: grant needs an earlier request; invalidation of an owned line wins.
  always_comb begin
    inherit = '0;
    for (int i = 0; i < DEPTH; i++) begin
      upd[i].own = flg_q[i].own || (gnt_valid && gnt_hit[i] && flg_q[i].req);
      upd[i].req = flg_q[i].req || (pf_fire && pf_hit[i]);
      if (inv_valid && inv_hit[i] && upd[i].own) begin
        upd[i] = '0;
      end
      if (wr_hit[i]) begin
        inherit.req = inherit.req || upd[i].req;
        inherit.own = inherit.own || upd[i].own;
      end
    end
  end

  // Shift queue: head at index 0; pop shifts down, push lands after the last live entry.
  always_comb begin
    addr_n = addr_q;
    data_n = data_q;
    flg_n  = upd;
    if (cm_fire) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        addr_n[i] = addr_q[i+1];
        data_n[i] = data_q[i+1];
        flg_n[i]  = upd[i+1];
      end
      flg_n[DEPTH-1] = '0;
    end
    slot = cnt_q - CW'(cm_fire);
    if (wr_fire) begin
      addr_n[slot[IW-1:0]] = wr_addr;
      data_n[slot[IW-1:0]] = wr_data;
      flg_n[slot[IW-1:0]]  = inherit;
    end
    cnt_n = cnt_q + CW'(wr_fire) - CW'(cm_fire);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      flg_q  <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_n;
      data_q <= data_n;
      flg_q  <= flg_n;
      cnt_q  <= cnt_n;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt_q == $past(cnt_q) + CW'($past(wr_fire)) - CW'($past(cm_fire))); // R1
  AST_RD_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |-> !cm_valid && !pf_valid); // R2
  AST_CM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && !cm_ready && !inv_valid |=> cm_valid && $stable(cm_addr) && $stable(cm_data)); // R3
  AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready && !inv_valid |=> pf_valid && $stable(pf_addr)); // R5
  AST_PF_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_fire && !inv_valid |=> !(pf_valid && pf_addr == $past(pf_addr))); // R6
endmodule

// File: tb/own_prefetch_wbuf_bench.sv
module own_prefetch_wbuf_bench;
  localparam int DEPTH = 8;
  localparam int AW    = 12;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid, wr_ready;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          rd_valid, rd_ready, rd_issue;
  logic          pf_valid, pf_ready;
  logic [AW-1:0] pf_addr;
  logic          gnt_valid;
  logic [AW-1:0] gnt_addr;
  logic          inv_valid;
  logic [AW-1:0] inv_addr;
  logic          cm_valid, cm_ready;
  logic [AW-1:0] cm_addr;
  logic [DW-1:0] cm_data;

  always #4 clk = ~clk;

  own_prefetch_wbuf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_own_prefetch_wbuf (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_issue(rd_issue),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
    .gnt_valid(gnt_valid), .gnt_addr(gnt_addr),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_addr(cm_addr), .cm_data(cm_data));

  typedef struct {
    int addr;
    int data;
    bit req;
    bit own;
  } ment_t;
  ment_t mq[$];

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  int  seq    = 1;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_valid = 0; wr_addr = '0; wr_data = '0; rd_valid = 0; pf_ready = 0;
    gnt_valid = 0; gnt_addr = '0; inv_valid = 0; inv_addr = '0; cm_ready = 0;
  endtask

  function automatic int oldest_unreq();
    for (int i = 0; i < mq.size(); i++) if (!mq[i].req) return i;
    return -1;
  endfunction

  // Compare every output with the model, then advance the model by one clock.
  task automatic cycle();
    int  pfi;
    bit  exp_cm, wr_f, pf_f, cm_f, ir, io;
    int  pfa;
    ment_t e;
    pfi    = oldest_unreq();
    exp_cm = (mq.size() > 0) && mq[0].own;
    chk("R1 wr_ready", int'(wr_ready), int'(mq.size() < DEPTH));
    chk("R2 rd_ready", int'(rd_ready), int'(mq.size() == 0));
    chk("R2 rd_issue", int'(rd_issue), int'(rd_valid && mq.size() == 0));
    chk("R5 pf_valid", int'(pf_valid), int'(pfi >= 0));
    if (pfi >= 0) chk("R5 pf_addr", int'(pf_addr), mq[pfi].addr);
    chk("R4 cm_valid", int'(cm_valid), int'(exp_cm));
    if (mq.size() > 0) begin
      chk("R3 cm_addr", int'(cm_addr), mq[0].addr);
      chk("R3 cm_data", int'(cm_data), mq[0].data);
    end
    wr_f = wr_valid && (mq.size() < DEPTH);
    pf_f = (pfi >= 0) && pf_ready;
    pfa  = (pfi >= 0) ? mq[pfi].addr : -1;
    cm_f = exp_cm && cm_ready;
    foreach (mq[i]) begin
      if (gnt_valid && mq[i].addr == int'(gnt_addr) && mq[i].req) mq[i].own = 1;
      if (pf_f && mq[i].addr == pfa) mq[i].req = 1;
      if (inv_valid && mq[i].addr == int'(inv_addr) && mq[i].own) begin
        mq[i].own = 0; mq[i].req = 0;
      end
    end
    ir = 0; io = 0;
    foreach (mq[i]) if (mq[i].addr == int'(wr_addr)) begin ir |= mq[i].req; io |= mq[i].own; end
    if (cm_f) void'(mq.pop_front());
    if (wr_f) begin
      e.addr = int'(wr_addr); e.data = int'(wr_data); e.req = ir; e.own = io;
      mq.push_back(e);
    end
    @(negedge clk);
    idle();
  endtask

  task automatic put(int a);
    wr_valid = 1; wr_addr = AW'(a); wr_data = DW'(32'hD000_0000 + seq); seq++;
  endtask

  task automatic drain();
    for (int k = 0; k < 400 && mq.size() > 0; k++) begin
      pf_ready = 1; gnt_valid = 1; gnt_addr = AW'(mq[0].addr); cm_ready = 1;
      cycle();
    end
    chk("R2 drained", int'(rd_ready), 1);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R9 wr_ready", int'(wr_ready), 1);
    chk("R9 rd_ready", int'(rd_ready), 1);
    chk("R9 pf_valid", int'(pf_valid), 0);
    chk("R9 cm_valid", int'(cm_valid), 0);
    rst_n = 1;

    // R6: second store to a requested line makes no new request
    put(12'h011); cycle();
    pf_ready = 1; put(12'h011); cycle();
    chk("R6 no second request", int'(pf_valid), 0);
    gnt_valid = 1; gnt_addr = 12'h011; cycle();
    chk("R4 granted head offered", int'(cm_valid), 1);
    cm_ready = 1; cycle();
    chk("R6 inherited grant", int'(cm_valid), 1);
    cm_ready = 1; cycle();
    chk("R3 both committed", int'(rd_ready), 1);

    // R7: stray grants ignored
    put(12'h022); gnt_valid = 1; gnt_addr = 12'h022; cycle();
    gnt_valid = 1; gnt_addr = 12'h022; cycle();
    chk("R7 unrequested grant ignored", int'(cm_valid), 0);
    chk("R7 request still due", int'(pf_valid), 1);
    drain();

    // R8: invalidation revokes, then same-cycle grant and invalidation
    put(12'h033); cycle();
    pf_ready = 1; cycle();
    inv_valid = 1; inv_addr = 12'h033; cycle();
    chk("R8 ungranted inv no effect", int'(pf_valid), 0);
    gnt_valid = 1; gnt_addr = 12'h033; cycle();
    chk("R4 owned", int'(cm_valid), 1);
    inv_valid = 1; inv_addr = 12'h033; cycle();
    chk("R8 grant revoked", int'(cm_valid), 0);
    chk("R8 re-request", int'(pf_valid), 1);
    chk("R8 re-request addr", int'(pf_addr), 12'h033);
    pf_ready = 1; cycle();
    gnt_valid = 1; gnt_addr = 12'h033; inv_valid = 1; inv_addr = 12'h033; cycle();
    chk("R8 inv beats grant", int'(cm_valid), 0);
    drain();

    // R1/R2: fill to full, refuse store even with a commit in the same cycle
    for (int i = 0; i < DEPTH; i++) begin put(12'h100 + i); cycle(); end
    chk("R1 full stall", int'(wr_ready), 0);
    rd_valid = 1; cycle();
    chk("R2 read held", int'(rd_issue), 0);
    pf_ready = 1; cycle();
    gnt_valid = 1; gnt_addr = 12'h100; cycle();
    put(12'h1FF); cm_ready = 1; cycle();
    chk("R1 no accept while full", int'(wr_ready), 1);
    drain();

    // Random traffic over a small line pool
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 99) < 55) put($urandom_range(0, 5));
      rd_valid  = ($urandom_range(0, 99) < 20);
      pf_ready  = ($urandom_range(0, 99) < 50);
      gnt_valid = ($urandom_range(0, 99) < 40);
      gnt_addr  = AW'($urandom_range(0, 5));
      inv_valid = ($urandom_range(0, 99) < 10);
      inv_addr  = AW'($urandom_range(0, 5));
      cm_ready  = ($urandom_range(0, 99) < 60);
      cycle();
    end
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule